// File: doc/BRIEF.md
# Hardware standby entry controller

This block takes a chip into and out of its hardware standby power-down state. An active-low standby request pin is sampled on a slow real-time clock of nominally 32.768 kHz. The block acts on the request only after the pin has read low on two slow-clock edges in a row. The qualified request then crosses into the bus-clock domain through a two-flop synchronizer. A bus-clock sequencer first changes the two-bit status output to the standby code. A fixed number of bus cycles later it drops the bus clock enable and the oscillator enable.

Once in standby, the block stays there for as long as the request pin is low. Raising the request pin alone does not wake it. The only way out is to drive the active-low reset pin low first and then release the request pin. Releasing the request pin restarts the oscillator and the bus clock and shows the reset status. The block returns to normal status on the first bus clock edge after the reset pin goes high. A separate power-on reset initialises both clock domains.

Top module: `hsby_ctrl`

## Requirements
- R1: A request pin that reads low on only one slow-clock edge and then reads high clears the qualification count. Status stays `00` and bus_ck_en stays 1.
- R2: Entry begins when the request pin reads low on two consecutive slow-clock edges. The standby status appears no fewer than STS_DLY and no more than STS_DLY+4 bus cycles after the second of those edges.
- R3: In normal operation status is `00` (status[1]=0, status[0]=0), and bus_ck_en and osc_en are both 1. The code `10` never appears.
- R4: In standby status is `01` (status[1]=0, status[0]=1), and bus_ck_en and osc_en are both 0.
- R5: The reset phase shows status `11` with bus_ck_en and osc_en at 1. This is the state after power-on reset, and it is held while rst_n is low.
- R6: After status turns `01`, bus_ck_en stays 1 for exactly CKSTOP_DLY bus cycles and then falls. It falls only from the standby status.
- R7: In standby, raising the request pin while rst_n has stayed high leaves every output unchanged. Lowering the pin again also changes nothing.
- R8: In standby, driving rst_n low alone keeps the block in standby. Releasing the request pin after rst_n has gone low brings status `11`, bus_ck_en 1 and osc_en 1. This happens within 24 bus cycles of the release, that is, one slow-clock edge plus the synchronizer delay.
- R9: From the reset status, the first bus clock edge that sees rst_n high gives status `00`.
- R10: While the bus clock is running, rst_n low gives status `11` at the next bus clock edge. This also applies part way through an entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rtc_clk | input | 1 | Slow real-time clock that samples the request pin |
| bus_clk | input | 1 | Bus clock that runs the sequencer |
| por_n | input | 1 | Active-low power-on reset for both domains |
| sby_req_n | input | 1 | Active-low hardware standby request pin |
| rst_n | input | 1 | Active-low chip reset pin, the only path out of standby |
| status | output | 2 | Mode code: 00 normal, 01 standby, 11 reset |
| bus_ck_en | output | 1 | Enable of the bus clock output |
| osc_en | output | 1 | Enable of the oscillator |

## Verification
The request pin is tried in several ways: single-sample glitches, glitches repeated with one high sample between them, and a held low level. These show whether the qualifier needs two consecutive low samples or only counts low samples. In standby, the bench raises the request pin with reset high and also drives reset low without releasing the pin. This separates a block that insists on both exit conditions, in order, from one that accepts either condition alone. Random hold times on reset, and optional resets from normal mode, test that the reset status tracks the pin and ends on the first edge after its release.

// File: rtl/hsby_pkg.sv
package hsby_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL   = 3'd0,
        ST_ENTER    = 3'd1,
        ST_STOPPING = 3'd2,
        ST_STANDBY  = 3'd3,
        ST_RESET    = 3'd4
    } hsby_state_e;

    localparam logic [1:0] STS_NORMAL  = 2'b00;
    localparam logic [1:0] STS_STANDBY = 2'b01;
    localparam logic [1:0] STS_RESET   = 2'b11;

endpackage

// File: rtl/hsby_req_qual.sv
// Slow-clock qualifier: counts consecutive low samples of the request pin.
module hsby_req_qual #(
    parameter int QUAL_SAMPLES = 2
) (
    input  logic rtc_clk,
    input  logic por_n,
    input  logic req_n,
    output logic qual
);
    localparam int CW = $clog2(QUAL_SAMPLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          qual;
    } qual_t;

    qual_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (req_n) begin
            r_d.cnt  = '0;
        end else if (r_q.cnt != CW'(QUAL_SAMPLES)) begin
            r_d.cnt  = r_q.cnt + 1'b1;
        end
        r_d.qual = (r_d.cnt == CW'(QUAL_SAMPLES));
    end

    always_ff @(posedge rtc_clk or negedge por_n) begin
        if (!por_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign qual = r_q.qual;
endmodule

// File: rtl/hsby_sync.sv
// Multi-stage level synchronizer into the bus-clock domain.
module hsby_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff_d, ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb ff_d = din;
        end else begin : g_chain
            always_comb ff_d = {ff_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/hsby_seq.sv
// Bus-clock sequencer: entry spacing, standby hold and reset-gated exit.
module hsby_seq
    import hsby_pkg::*;
#(
    parameter int STS_DLY    = 4,
    parameter int CKSTOP_DLY = 8
) (
    input  logic       bus_clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       qual_s,
    output logic [1:0] status,
    output logic       bus_ck_en,
    output logic       osc_en,
    output logic       armed
);
    localparam int DLY_MAX = (STS_DLY > CKSTOP_DLY) ? STS_DLY : CKSTOP_DLY;
    localparam int CW      = $clog2(DLY_MAX + 1);

    typedef struct packed {
        hsby_state_e   state;
        logic [CW-1:0] cnt;
        logic          armed;
        logic [1:0]    status;
        logic          ck_en;
        logic          osc_en;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_NORMAL: begin
                if (!rst_n) begin
                    s_d.state = ST_RESET;
                end else if (qual_s) begin
                    s_d.state = ST_ENTER;
                    s_d.cnt   = '0;
                end
            end
            ST_ENTER: begin
                if (!rst_n) begin
                    s_d.state = ST_RESET;
                end else if (s_q.cnt == CW'(STS_DLY - 1)) begin
                    s_d.state = ST_STOPPING;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt   = s_q.cnt + 1'b1;
                end
            end
            ST_STOPPING: begin
                if (!rst_n) begin
                    s_d.state = ST_RESET;
                end else if (s_q.cnt == CW'(CKSTOP_DLY - 1)) begin
                    s_d.state = ST_STANDBY;
                    s_d.armed = 1'b0;
                end else begin
                    s_d.cnt   = s_q.cnt + 1'b1;
                end
            end
            ST_STANDBY: begin
                if (!rst_n) s_d.armed = 1'b1;
                if (!qual_s && (s_q.armed || !rst_n)) begin
                    s_d.state = ST_RESET;
                    s_d.armed = 1'b0;
                end
            end
            ST_RESET: begin
                if (rst_n) s_d.state = ST_NORMAL;
            end
            default: s_d.state = ST_RESET;
        endcase

        // registered pin values follow the next state
        unique case (s_d.state)
            ST_STOPPING: begin
                s_d.status = STS_STANDBY; s_d.ck_en = 1'b1; s_d.osc_en = 1'b1;
            end
            ST_STANDBY: begin
                s_d.status = STS_STANDBY; s_d.ck_en = 1'b0; s_d.osc_en = 1'b0;
            end
            ST_RESET: begin
                s_d.status = STS_RESET;   s_d.ck_en = 1'b1; s_d.osc_en = 1'b1;
            end
            default: begin
                s_d.status = STS_NORMAL;  s_d.ck_en = 1'b1; s_d.osc_en = 1'b1;
            end
        endcase
    end

    always_ff @(posedge bus_clk or negedge por_n) begin
        if (!por_n) begin
            s_q        <= '0;
            s_q.state  <= ST_RESET;
            s_q.status <= STS_RESET;
            s_q.ck_en  <= 1'b1;
            s_q.osc_en <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign status    = s_q.status;
    assign bus_ck_en = s_q.ck_en;
    assign osc_en    = s_q.osc_en;
    assign armed     = s_q.armed;
endmodule

// File: rtl/hsby_ctrl.sv
module hsby_ctrl #(
    parameter int QUAL_SAMPLES = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int STS_DLY      = 4,
    parameter int CKSTOP_DLY   = 8
) (
    input  logic       rtc_clk,
    input  logic       bus_clk,
    input  logic       por_n,
    input  logic       sby_req_n,
    input  logic       rst_n,
    output logic [1:0] status,
    output logic       bus_ck_en,
    output logic       osc_en
);
    logic qual_rtc;
    logic qual_bus;
    logic seq_armed;

    hsby_req_qual #(.QUAL_SAMPLES(QUAL_SAMPLES)) u_qual (
        .rtc_clk (rtc_clk),
        .por_n   (por_n),
        .req_n   (sby_req_n),
        .qual    (qual_rtc)
    );

    hsby_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (bus_clk),
        .por_n (por_n),
        .din   (qual_rtc),
        .dout  (qual_bus)
    );

    hsby_seq #(.STS_DLY(STS_DLY), .CKSTOP_DLY(CKSTOP_DLY)) u_seq (
        .bus_clk   (bus_clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .qual_s    (qual_bus),
        .status    (status),
        .bus_ck_en (bus_ck_en),
        .osc_en    (osc_en),
        .armed     (seq_armed)
    );
endmodule

// File: rtl/hsby_chk.sv
module hsby_chk (
    input logic       bus_clk,
    input logic       por_n,
    input logic       rst_n,
    input logic [1:0] status,
    input logic       bus_ck_en,
    input logic       osc_en,
    input logic       armed
);
    // R6
    ckstop_from_standby_chk: assert property (@(posedge bus_clk) disable iff (!por_n)
        $fell(bus_ck_en) |-> $past(status) == 2'b01);

    // R4
    standby_pins_chk: assert property (@(posedge bus_clk) disable iff (!por_n)
        !bus_ck_en |-> (status == 2'b01 && !osc_en));

    // R7
    standby_hold_chk: assert property (@(posedge bus_clk) disable iff (!por_n)
        (!bus_ck_en && rst_n && !armed) |=> !bus_ck_en);

    // R10
    reset_wins_chk: assert property (@(posedge bus_clk) disable iff (!por_n)
        (!rst_n && bus_ck_en) |=> status == 2'b11);

    // R9
    reset_release_chk: assert property (@(posedge bus_clk) disable iff (!por_n)
        (status == 2'b11 && rst_n) |=> status == 2'b00);

    // R3
    no_unused_code_chk: assert property (@(posedge bus_clk) disable iff (!por_n)
        status != 2'b10);
endmodule

bind hsby_ctrl hsby_chk u_chk (
    .bus_clk   (bus_clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .status    (status),
    .bus_ck_en (bus_ck_en),
    .osc_en    (osc_en),
    .armed     (seq_armed)
);

// File: tb/sim_hsby_ctrl.sv
module sim_hsby_ctrl;
    localparam int STS_DLY    = 4;
    localparam int CKSTOP_DLY = 8;
    localparam int M_NORM = 0, M_SBY = 1, M_RST = 2;

    logic bus_clk = 1'b0, rtc_clk = 1'b0;
    logic por_n = 1'b0, sby_req_n = 1'b1, rst_n = 1'b0;
    logic [1:0] status;
    logic bus_ck_en, osc_en;
    logic [3:0] pins;
    int n_chk = 0, n_bad = 0;

    assign pins = {status, bus_ck_en, osc_en};

    always #10  bus_clk = ~bus_clk;   // 50 MHz
    always #320 rtc_clk = ~rtc_clk;   // scaled slow clock

    hsby_ctrl #(.STS_DLY(STS_DLY), .CKSTOP_DLY(CKSTOP_DLY)) u0 (
        .rtc_clk(rtc_clk), .bus_clk(bus_clk), .por_n(por_n),
        .sby_req_n(sby_req_n), .rst_n(rst_n),
        .status(status), .bus_ck_en(bus_ck_en), .osc_en(osc_en)
    );

    function automatic logic [3:0] mode_pins(int m);
        case (m)
            M_SBY:   return {2'b01, 1'b0, 1'b0};
            M_RST:   return {2'b11, 1'b1, 1'b1};
            default: return {2'b00, 1'b1, 1'b1};
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus(int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic rtc(int n);
        repeat (n) @(negedge rtc_clk);
    endtask

    task automatic glitch();
        @(negedge rtc_clk) sby_req_n = 1'b0;
        @(negedge rtc_clk) sby_req_n = 1'b1;
        @(negedge rtc_clk) sby_req_n = 1'b0;
        @(negedge rtc_clk) sby_req_n = 1'b1;
        rtc(3);
        @(negedge bus_clk);
        chk("R1", 32'(pins), 32'(mode_pins(M_NORM)));
    endtask

    task automatic enter();
        int n = 0, k = 0;
        @(negedge rtc_clk) sby_req_n = 1'b0;
        @(posedge rtc_clk);
        @(posedge rtc_clk);
        while (status !== 2'b01 && n < 40) begin
            @(negedge bus_clk);
            n++;
        end
        chk("R2", 32'(n >= STS_DLY && n <= STS_DLY + 4), 32'd1);
        chk("R4", 32'(status), 32'h1);
        while (status === 2'b01 && bus_ck_en === 1'b1 && k < 64) begin
            k++;
            @(negedge bus_clk);
        end
        chk("R6", 32'(k), 32'(CKSTOP_DLY));
        chk("R4", 32'(pins), 32'(mode_pins(M_SBY)));
    endtask

    task automatic illegal();
        @(negedge rtc_clk) sby_req_n = 1'b1;
        rtc(3);
        @(negedge bus_clk);
        chk("R7", 32'(pins), 32'(mode_pins(M_SBY)));
        @(negedge rtc_clk) sby_req_n = 1'b0;
        rtc(3);
        @(negedge bus_clk);
        chk("R7", 32'(pins), 32'(mode_pins(M_SBY)));
    endtask

    task automatic leave(int hold);
        int n = 0;
        @(negedge bus_clk) rst_n = 1'b0;
        bus(5);
        chk("R8", 32'(pins), 32'(mode_pins(M_SBY)));
        @(negedge rtc_clk) sby_req_n = 1'b1;
        while (status !== 2'b11 && n < 64) begin
            @(negedge bus_clk);
            n++;
        end
        chk("R8", 32'(pins), 32'(mode_pins(M_RST)));
        chk("R8", 32'(n <= 24), 32'd1);
        repeat (hold) begin
            @(negedge bus_clk);
            chk("R5", 32'(pins), 32'(mode_pins(M_RST)));
        end
        rst_n = 1'b1;
        @(negedge bus_clk);
        chk("R9", 32'(pins), 32'(mode_pins(M_NORM)));
    endtask

    task automatic reset_in_normal(int hold);
        @(negedge bus_clk) rst_n = 1'b0;
        @(negedge bus_clk);
        chk("R10", 32'(pins), 32'(mode_pins(M_RST)));
        bus(hold);
        chk("R5", 32'(pins), 32'(mode_pins(M_RST)));
        rst_n = 1'b1;
        @(negedge bus_clk);
        chk("R9", 32'(pins), 32'(mode_pins(M_NORM)));
    endtask

    initial begin
        void'($urandom(32'd7717));
        bus(3);
        chk("R5", 32'(pins), 32'(mode_pins(M_RST)));
        por_n = 1'b1;
        bus(3);
        chk("R5", 32'(pins), 32'(mode_pins(M_RST)));
        rst_n = 1'b1;
        @(negedge bus_clk);
        chk("R9", 32'(pins), 32'(mode_pins(M_NORM)));
        glitch();
        for (int round = 0; round < 6; round++) begin
            if ($urandom % 2 == 0) glitch();
            enter();
            if (round == 0 || $urandom % 2 == 0) illegal();
            leave(int'($urandom_range(1, 6)));
            if ($urandom % 2 == 0) reset_in_normal(int'($urandom_range(1, 5)));
            rtc(2);
            @(negedge bus_clk);
            chk("R3", 32'(pins), 32'(mode_pins(M_NORM)));
        end
        // reset part way through an entry
        @(negedge rtc_clk) sby_req_n = 1'b0;
        @(posedge rtc_clk);
        @(posedge rtc_clk);
        bus(4);
        reset_in_normal(2);
        @(negedge rtc_clk) sby_req_n = 1'b1;
        rtc(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge bus_clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule